// File: doc/BRIEF.md
# Instruction Dispatch Classifier Router

This block sits between the rename stage and the out-of-order back end. Each cycle it may receive a group of up to `N` renamed instructions. Each slot carries five class flags and a tag. The block visits the slots in ascending order, up to the group's valid count. A fixed priority chain picks one route for each slot. The possible routes are:

- drop the slot;
- halt the group on a full issue queue;
- send it to the load side of the load/store queue;
- send it to the store side of the load/store queue;
- send it to a separate port for non-speculative instructions;
- retire it as a no-op by advancing the issue queue tail;
- insert it into the issue queue.

The routing decisions are registered and come out one cycle later as per-slot write strobes. Each strobe comes with the slot's tag and with per-slot "executed" and "ready to commit" marks. A full issue queue does two things. It stops the walk at the first slot that is not squashed, and it raises a stall to rename in the same cycle, combinationally. One cycle later it raises a registered block request. Six saturating counters record the number of events of each kind. The queues themselves are outside the block.

Top module: `dispatch_router`

## Requirements
- R1: During and right after synchronous active-low reset, all strobes, marks and `block_req` are 0 and every counter reads 0.
- R2: Only slots with index below `grp_count` and only cycles with `grp_valid` high are considered; results appear on the outputs one clock after the group is presented, and a cycle without a group leaves every strobe 0.
- R3: When `iq_full` is high, the first considered slot that is not squashed halts the group: that slot and all higher slots produce no strobe, `block_req` is 1 in the next cycle and `cnt_iqfull` rises by one.
- R4: A squashed slot (before any halt) produces no strobe and adds one to `cnt_squash`.
- R5: A load slot raises its bit of `lsq_ld_wr` and adds one to `cnt_load`.
- R6: A store slot raises its bit of `lsq_st_wr` and adds one to `cnt_store`.
- R7: A non-speculative slot raises its bits of `nsp_wr` and `commit_ok` and adds one to `cnt_nonspec`.
- R8: A no-op slot raises its bits of `tail_adv`, `exec_done` and `commit_ok`, is not inserted anywhere and changes no counter.
- R9: A slot with no class flag raises its bit of `iq_wr` and adds one to `cnt_disp`.
- R10: A slot with several flags follows this order: squashed, full check, load, store, non-speculative, no-op, general. At most one of the five write strobes of a slot is high.
- R11: Every counter is `CNT_W` bits wide and stops at its all-ones value instead of wrapping.
- R12: `stall_up` is high in the same cycle as a group that halts under R3, and low otherwise.
- R13: `wr_tag` slice i carries the tag of slot i in the cycle its strobe is high (tag i is bits [i*TAG_W +: TAG_W]).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_valid | input | 1 | A group is presented this cycle |
| grp_count | input | $clog2(N+1) | Number of valid slots, counted from slot 0 |
| f_squash | input | N | Per-slot squashed flag |
| f_load | input | N | Per-slot load flag |
| f_store | input | N | Per-slot store flag |
| f_nonspec | input | N | Per-slot non-speculative flag |
| f_nop | input | N | Per-slot no-op flag |
| slot_tag | input | N*TAG_W | Per-slot tags |
| iq_full | input | 1 | Issue queue has no free entry |
| stall_up | output | 1 | Combinational stall to rename |
| iq_wr | output | N | Issue queue insert strobes |
| lsq_ld_wr | output | N | Load-side insert strobes |
| lsq_st_wr | output | N | Store-side insert strobes |
| nsp_wr | output | N | Non-speculative insert strobes |
| tail_adv | output | N | Issue queue tail advance for no-ops |
| commit_ok | output | N | Ready-to-commit marks |
| exec_done | output | N | Issued/executed marks |
| wr_tag | output | N*TAG_W | Registered slot tags |
| block_req | output | 1 | Registered block request |
| cnt_squash | output | CNT_W | Dropped squashed slots |
| cnt_iqfull | output | CNT_W | Groups halted by a full issue queue |
| cnt_load | output | CNT_W | Dispatched loads |
| cnt_store | output | CNT_W | Dispatched stores |
| cnt_nonspec | output | CNT_W | Dispatched non-speculative slots |
| cnt_disp | output | CNT_W | General issue queue inserts |

## Verification
The assertions assume three things about the inputs. `grp_count` never exceeds `N`. `iq_full` is constant while a group is presented. Flags on slots beyond the count carry no meaning. The bench drives counts only from 0 to N and holds `iq_full` for a whole cycle. It fills the unused slots with arbitrary flags, so that any leak of those flags would show up as a strobe. The counters are shrunk to six bits, which lets a short run of general-only groups reach saturation.

// File: rtl/dcr_pkg.sv
// Package: shared route encoding for the dispatch classifier router.
// Assumes nothing beyond IEEE 1800-2017 enums.
package dcr_pkg;

    typedef enum logic [2:0] {
        RT_NONE  = 3'd0,  // slot not considered
        RT_DROP  = 3'd1,  // squashed, discarded
        RT_HALT  = 3'd2,  // issue queue full, group stops here
        RT_LOAD  = 3'd3,
        RT_STORE = 3'd4,
        RT_NSPEC = 3'd5,
        RT_NOP   = 3'd6,
        RT_GEN   = 3'd7
    } route_e;

    localparam int NUM_CNT = 6;
    localparam int C_SQ    = 0;
    localparam int C_FULL  = 1;
    localparam int C_LD    = 2;
    localparam int C_ST    = 3;
    localparam int C_NS    = 4;
    localparam int C_GEN   = 5;

endpackage

// File: rtl/dcr_group_walk.sv
// Module: dcr_group_walk
// Walks the slots of a group in ascending order and tells which slots are
// reached. A slot is reached when it is inside the valid count and no lower
// slot has halted on a full issue queue. Assumes iq_full is stable for the
// cycle in which the group is presented.
module dcr_group_walk #(
    parameter int N = 4
) (
    input  logic [N-1:0] active,
    input  logic [N-1:0] squash,
    input  logic         iq_full,
    output logic [N-1:0] reached,
    output logic         halt
);

    logic [N:0] open_chain;  // open_chain[i]: no halt below slot i

    assign open_chain[0] = 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_walk
            // reached when still open and valid; closes on a non-squashed slot under full
            assign reached[gi]      = active[gi] & open_chain[gi];
            assign open_chain[gi+1] = open_chain[gi] &
                                      ~(reached[gi] & ~squash[gi] & iq_full);
        end
    endgenerate

    assign halt = ~open_chain[N];

endmodule

// File: rtl/dcr_slot_route.sv
// Module: dcr_slot_route
// Picks the route of one slot by fixed priority: squashed, full check,
// load, store, non-speculative, no-op, general. Purely combinational.
module dcr_slot_route
    import dcr_pkg::*;
(
    input  logic   reached,
    input  logic   iq_full,
    input  logic   is_squash,
    input  logic   is_load,
    input  logic   is_store,
    input  logic   is_nonspec,
    input  logic   is_nop,
    output route_e route
);

    // priority chain for one slot
    always_comb begin
        if (!reached)        route = RT_NONE;
        else if (is_squash)  route = RT_DROP;
        else if (iq_full)    route = RT_HALT;
        else if (is_load)    route = RT_LOAD;
        else if (is_store)   route = RT_STORE;
        else if (is_nonspec) route = RT_NSPEC;
        else if (is_nop)     route = RT_NOP;
        else                 route = RT_GEN;
    end

endmodule

// File: rtl/dcr_sat_counter.sv
// Module: dcr_sat_counter
// Event counter that adds a small increment per cycle and holds at its
// all-ones value. Synchronous active-low reset clears it. Assumes W > IW.
module dcr_sat_counter #(
    parameter int W  = 32,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  value
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] inc_w;
    logic [W-1:0] room;

    assign inc_w = W'(inc);
    assign room  = TOP - value;

    // accumulate with saturation
    always_ff @(posedge clk) begin
        if (!rst_n)            value <= '0;
        else if (inc_w > room) value <= TOP;
        else                   value <= value + inc_w;
    end

endmodule

// File: rtl/dispatch_router.sv
// Module: dispatch_router
// Routes a group of up to N renamed instructions to the issue queue, the
// load or store side of the load/store queue, the non-speculative port or
// the no-op tail advance. Decisions are registered; stall_up is
// combinational. Assumes grp_count <= N and iq_full stable per cycle.
module dispatch_router
    import dcr_pkg::*;
#(
    parameter int N     = 4,
    parameter int TAG_W = 8,
    parameter int CNT_W = 32,
    localparam int CIW  = $clog2(N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_valid,
    input  logic [CIW-1:0]   grp_count,
    input  logic [N-1:0]     f_squash,
    input  logic [N-1:0]     f_load,
    input  logic [N-1:0]     f_store,
    input  logic [N-1:0]     f_nonspec,
    input  logic [N-1:0]     f_nop,
    input  logic [N*TAG_W-1:0] slot_tag,
    input  logic             iq_full,
    output logic             stall_up,
    output logic [N-1:0]     iq_wr,
    output logic [N-1:0]     lsq_ld_wr,
    output logic [N-1:0]     lsq_st_wr,
    output logic [N-1:0]     nsp_wr,
    output logic [N-1:0]     tail_adv,
    output logic [N-1:0]     commit_ok,
    output logic [N-1:0]     exec_done,
    output logic [N*TAG_W-1:0] wr_tag,
    output logic             block_req,
    output logic [CNT_W-1:0] cnt_squash,
    output logic [CNT_W-1:0] cnt_iqfull,
    output logic [CNT_W-1:0] cnt_load,
    output logic [CNT_W-1:0] cnt_store,
    output logic [CNT_W-1:0] cnt_nonspec,
    output logic [CNT_W-1:0] cnt_disp
);

    logic [N-1:0]   active;
    logic [N-1:0]   reached;
    logic           halt;
    route_e         route [N];
    logic [CIW-1:0] inc [NUM_CNT];
    logic [CNT_W-1:0] cnt_val [NUM_CNT];

    genvar gi;

    // slot i is in the group when valid and below the count
    generate
        for (gi = 0; gi < N; gi++) begin : g_active
            assign active[gi] = grp_valid & (CIW'(gi) < grp_count);
        end
    endgenerate

    dcr_group_walk #(.N(N)) u_walk (
        .active  (active),
        .squash  (f_squash),
        .iq_full (iq_full),
        .reached (reached),
        .halt    (halt)
    );

    generate
        for (gi = 0; gi < N; gi++) begin : g_route
            dcr_slot_route u_route (
                .reached    (reached[gi]),
                .iq_full    (iq_full),
                .is_squash  (f_squash[gi]),
                .is_load    (f_load[gi]),
                .is_store   (f_store[gi]),
                .is_nonspec (f_nonspec[gi]),
                .is_nop     (f_nop[gi]),
                .route      (route[gi])
            );
        end
    endgenerate

    assign stall_up = halt;

    // per-class event counts for this group
    always_comb begin
        for (int k = 0; k < NUM_CNT; k++) inc[k] = '0;
        for (int i = 0; i < N; i++) begin
            case (route[i])
                RT_DROP:  inc[C_SQ]  = inc[C_SQ]  + 1'b1;
                RT_LOAD:  inc[C_LD]  = inc[C_LD]  + 1'b1;
                RT_STORE: inc[C_ST]  = inc[C_ST]  + 1'b1;
                RT_NSPEC: inc[C_NS]  = inc[C_NS]  + 1'b1;
                RT_GEN:   inc[C_GEN] = inc[C_GEN] + 1'b1;
                default:  ;
            endcase
        end
        inc[C_FULL] = CIW'(halt);
    end

    generate
        for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
            dcr_sat_counter #(.W(CNT_W), .IW(CIW)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (inc[gi]),
                .value (cnt_val[gi])
            );
        end
    endgenerate

    assign cnt_squash  = cnt_val[C_SQ];
    assign cnt_iqfull  = cnt_val[C_FULL];
    assign cnt_load    = cnt_val[C_LD];
    assign cnt_store   = cnt_val[C_ST];
    assign cnt_nonspec = cnt_val[C_NS];
    assign cnt_disp    = cnt_val[C_GEN];

    // register per-slot strobes and marks from the routes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iq_wr     <= '0;
            lsq_ld_wr <= '0;
            lsq_st_wr <= '0;
            nsp_wr    <= '0;
            tail_adv  <= '0;
            commit_ok <= '0;
            exec_done <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                iq_wr[i]     <= (route[i] == RT_GEN);
                lsq_ld_wr[i] <= (route[i] == RT_LOAD);
                lsq_st_wr[i] <= (route[i] == RT_STORE);
                nsp_wr[i]    <= (route[i] == RT_NSPEC);
                tail_adv[i]  <= (route[i] == RT_NOP);
                commit_ok[i] <= (route[i] == RT_NSPEC) || (route[i] == RT_NOP);
                exec_done[i] <= (route[i] == RT_NOP);
            end
        end
    end

    // register the block request raised by a halted group
    always_ff @(posedge clk) begin
        if (!rst_n) block_req <= 1'b0;
        else        block_req <= halt;
    end

    // capture tags of each presented group
    always_ff @(posedge clk) begin
        if (!rst_n)         wr_tag <= '0;
        else if (grp_valid) wr_tag <= slot_tag;
    end

endmodule

// File: rtl/dispatch_router_chk.sv
// Module: dispatch_router_chk
// Property checker for dispatch_router, attached with bind below.
// Assumes grp_count <= N.
module dispatch_router_chk #(
    parameter int N     = 4,
    parameter int CNT_W = 32,
    localparam int CIW  = $clog2(N + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             grp_valid,
    input logic [CIW-1:0]   grp_count,
    input logic             iq_full,
    input logic             stall_up,
    input logic [N-1:0]     iq_wr,
    input logic [N-1:0]     lsq_ld_wr,
    input logic [N-1:0]     lsq_st_wr,
    input logic [N-1:0]     nsp_wr,
    input logic [N-1:0]     tail_adv,
    input logic [N-1:0]     commit_ok,
    input logic [N-1:0]     exec_done,
    input logic             block_req,
    input logic [CNT_W-1:0] cnt_squash,
    input logic [CNT_W-1:0] cnt_disp
);

    logic [N-1:0] any_wr;
    assign any_wr = iq_wr | lsq_ld_wr | lsq_st_wr | nsp_wr | tail_adv;

    // R2: no group, no strobe or block next cycle
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !grp_valid |=> (any_wr == '0) && !block_req);

    // R3: a full issue queue leaves every write strobe low
    p_full_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && iq_full) |=> (any_wr == '0));

    // R3: block request only follows a full queue
    p_block_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        block_req |-> $past(grp_valid && iq_full));

    // R12: a stall is followed by the registered block request
    p_stall_then_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stall_up |=> block_req);

    // R11: counters never move backwards
    p_sq_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_squash >= $past(cnt_squash));
    p_disp_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_disp >= $past(cnt_disp));

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_slot
            // R10: one route per slot
            p_one_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0({iq_wr[gi], lsq_ld_wr[gi], lsq_st_wr[gi], nsp_wr[gi], tail_adv[gi]}));
            // R2: slots at or beyond the count stay quiet
            p_beyond_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (CIW'(gi) >= grp_count) |=> !any_wr[gi]);
            // R8: a no-op tail advance carries both marks
            p_nop_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
                tail_adv[gi] |-> (exec_done[gi] && commit_ok[gi] && !iq_wr[gi]));
        end
    endgenerate

endmodule

bind dispatch_router dispatch_router_chk #(.N(N), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_valid (grp_valid),
    .grp_count (grp_count),
    .iq_full   (iq_full),
    .stall_up  (stall_up),
    .iq_wr     (iq_wr),
    .lsq_ld_wr (lsq_ld_wr),
    .lsq_st_wr (lsq_st_wr),
    .nsp_wr    (nsp_wr),
    .tail_adv  (tail_adv),
    .commit_ok (commit_ok),
    .exec_done (exec_done),
    .block_req (block_req),
    .cnt_squash(cnt_squash),
    .cnt_disp  (cnt_disp)
);

// File: tb/dispatch_router_bench.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops
// and compares them one cycle later.
module dispatch_router_bench;

    localparam int N   = 4;
    localparam int TW  = 8;
    localparam int CW  = 6;
    localparam int CIW = 3;
    localparam int CMAX = 63;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grp_valid = 1'b0;
    logic [CIW-1:0] grp_count = '0;
    logic [N-1:0] f_squash = '0, f_load = '0, f_store = '0, f_nonspec = '0, f_nop = '0;
    logic [N*TW-1:0] slot_tag = '0;
    logic iq_full = 1'b0;
    logic stall_up, block_req;
    logic [N-1:0] iq_wr, lsq_ld_wr, lsq_st_wr, nsp_wr, tail_adv, commit_ok, exec_done;
    logic [N*TW-1:0] wr_tag;
    logic [CW-1:0] cnt_squash, cnt_iqfull, cnt_load, cnt_store, cnt_nonspec, cnt_disp;

    always #2 clk = ~clk;  // 250 MHz

    dispatch_router #(.N(N), .TAG_W(TW), .CNT_W(CW)) u_dispatch_router (.*);

    typedef struct packed {
        logic [N-1:0] iq, ld, st, ns, tl, co, ex;
        logic [N*TW-1:0] tg;
        logic blk;
        logic [CW-1:0] c_sq, c_full, c_ld, c_st, c_ns, c_gen;
    } exp_t;

    exp_t expq[$];
    int n_run = 0, n_fail = 0;
    int m_sq = 0, m_full = 0, m_ld = 0, m_st = 0, m_ns = 0, m_gen = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    // drive one cycle (group or idle) and push its expected result
    task automatic send(input logic v, input int cnt, input logic [N-1:0] sq, ld, st, ns, np,
                        input logic full, input logic [N*TW-1:0] tg);
        exp_t e;
        logic halt;
        @(negedge clk);
        grp_valid = v; grp_count = CIW'(cnt); f_squash = sq; f_load = ld; f_store = st;
        f_nonspec = ns; f_nop = np; iq_full = full; slot_tag = tg;
        e = '0; halt = 1'b0;
        if (v) begin
            for (int i = 0; i < cnt; i++) begin
                if (sq[i]) m_sq = sat(m_sq + 1);
                else if (full) begin halt = 1'b1; break; end
                else if (ld[i]) begin e.ld[i] = 1'b1; m_ld = sat(m_ld + 1); end
                else if (st[i]) begin e.st[i] = 1'b1; m_st = sat(m_st + 1); end
                else if (ns[i]) begin e.ns[i] = 1'b1; e.co[i] = 1'b1; m_ns = sat(m_ns + 1); end
                else if (np[i]) begin e.tl[i] = 1'b1; e.co[i] = 1'b1; e.ex[i] = 1'b1; end
                else begin e.iq[i] = 1'b1; m_gen = sat(m_gen + 1); end
            end
        end
        if (halt) m_full = sat(m_full + 1);
        e.blk = halt; e.tg = tg;
        e.c_sq = CW'(m_sq); e.c_full = CW'(m_full); e.c_ld = CW'(m_ld);
        e.c_st = CW'(m_st); e.c_ns = CW'(m_ns); e.c_gen = CW'(m_gen);
        expq.push_back(e);
        #1 chk("R12 stall_up", {31'd0, stall_up}, {31'd0, halt});
    endtask

    task automatic idle();
        send(1'b0, 0, '0, '0, '0, '0, '0, 1'b0, '0);
    endtask

    // monitor: compare one expected item per cycle
    always @(posedge clk) begin
        #1;
        if (expq.size() > 0) begin
            exp_t e;
            logic [N-1:0] wr;
            e = expq.pop_front();
            chk("R9 iq_wr", 32'(iq_wr), 32'(e.iq));
            chk("R5 lsq_ld_wr", 32'(lsq_ld_wr), 32'(e.ld));
            chk("R6 lsq_st_wr", 32'(lsq_st_wr), 32'(e.st));
            chk("R7 nsp_wr", 32'(nsp_wr), 32'(e.ns));
            chk("R8 tail_adv", 32'(tail_adv), 32'(e.tl));
            chk("R7 commit_ok", 32'(commit_ok), 32'(e.co));
            chk("R8 exec_done", 32'(exec_done), 32'(e.ex));
            chk("R3 block_req", 32'(block_req), 32'(e.blk));
            chk("R4 R11 cnt_squash", 32'(cnt_squash), 32'(e.c_sq));
            chk("R3 R11 cnt_iqfull", 32'(cnt_iqfull), 32'(e.c_full));
            chk("R5 R11 cnt_load", 32'(cnt_load), 32'(e.c_ld));
            chk("R6 R11 cnt_store", 32'(cnt_store), 32'(e.c_st));
            chk("R7 R11 cnt_nonspec", 32'(cnt_nonspec), 32'(e.c_ns));
            chk("R9 R11 cnt_disp", 32'(cnt_disp), 32'(e.c_gen));
            wr = e.iq | e.ld | e.st | e.ns | e.tl;
            for (int i = 0; i < N; i++)
                if (wr[i]) chk("R13 wr_tag", 32'(wr_tag[i*TW +: TW]), 32'(e.tg[i*TW +: TW]));
        end
    end

    bit done = 1'b0;
    initial begin
        #400000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        #1;
        chk("R1 strobes", 32'(iq_wr | lsq_ld_wr | lsq_st_wr | nsp_wr | tail_adv | commit_ok | exec_done), 0);
        chk("R1 block_req", 32'(block_req), 0);
        chk("R1 counters", 32'(cnt_squash | cnt_iqfull | cnt_load | cnt_store | cnt_nonspec | cnt_disp), 0);
        @(negedge clk); rst_n = 1'b1;
        idle();
        // R9: full group of general slots
        send(1, 4, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 32'h44332211);
        // R2: partial count, flags beyond count ignored
        send(1, 2, 4'b0000, 4'b1100, 4'b1000, 4'b0100, 4'b1000, 0, 32'hA0B0C0D0);
        // R5 R6 R7 R8: one of each class
        send(1, 4, 4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000, 0, 32'h0F1E2D3C);
        // R4: squashed slots dropped
        send(1, 4, 4'b1010, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 0, 32'h12345678);
        // R3: leading squashed counted, then halt at slot 1
        send(1, 4, 4'b0001, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 1, 32'h01020304);
        // R3: all squashed under full, no halt
        send(1, 3, 4'b0111, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 1, 32'h0);
        // R10: priority with multiple flags
        send(1, 4, 4'b0001, 4'b0011, 4'b0110, 4'b1100, 4'b1000, 0, 32'hCAFEF00D);
        // R2: valid with count 0, then no valid with flags set
        send(1, 0, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 1, 32'h0);
        send(0, 4, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 1, 32'h0);
        // mixed patterns
        for (int k = 0; k < 60; k++)
            send(1, int'($urandom_range(0, 4)), 4'($urandom), 4'($urandom), 4'($urandom),
                 4'($urandom), 4'($urandom), ($urandom_range(0, 3) == 0), $urandom);
        // R11: drive general counts past saturation
        for (int k = 0; k < 20; k++)
            send(1, 4, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, $urandom);
        idle();
        idle();
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule